// File: doc/BRIEF.md
# Command Register with Parity Gating

This block is a one-stage register between a memory controller and a two-rank DRAM array. On every clock it captures the command and address lines, the bank and bank-group lines, the activate strobe, a parity bit and the per-rank clock-enable and termination-enable lines. Each of the two active-low chip-select inputs selects one rank directly. A cycle in which either select is low is a qualified command, and only qualified commands are checked for parity. While checking is on, a command whose parity does not match is turned into a deselect and never reaches the DRAM side.

On a parity mismatch the block pulls an active-low alarm output low for a programmable number of cycles and sets a sticky error flag. The alarm is driven by a two-state machine. State AL_QUIET moves to AL_HOLD on an error and loads the countdown. In AL_HOLD a new error reloads the countdown and the machine stays in AL_HOLD. AL_HOLD returns to AL_QUIET when the countdown expires.

The host writes three small control words over the same command bus:
- a configuration word that holds the parity-check enable;
- a word that holds the alarm length;
- a word that clears the sticky flag.

The odd rank receives its own copy of the address, bank and bank-group lines with fixed bit pairs swapped, which lets the board route that rank mirrored. The even rank receives the lines unchanged.

Top module: `ca_parity_reg`

## Requirements
- R1: While reset is held, and right after it is released, both select outputs are high, the alarm output is high, the sticky flag is 0 and both clock-enable outputs are 0. After reset, parity checking is enabled and the alarm length equals parameter ALERT_DEF.
- R2: A qualified command (at least one select input low) with correct even parity that is not a control-word write appears on the select outputs one clock after it is sampled, with the same select pattern. The rank-0 address appears one clock after sampling, unchanged.
- R3: With checking enabled, a qualified command with a parity mismatch is blocked: one clock later both select outputs are high.
- R4: The parity of a cycle is correct when the XOR of the address, bank, bank-group, activate and three command lines together with the parity bit is 0. After an error the alarm output goes low on the next clock and stays low for exactly L cycles, where L is the programmed length (a length of 0 counts as 1). A new error while the alarm is low restarts the count.
- R5: With checking disabled (configuration word bit 0 = 0), commands are forwarded whatever their parity, no alarm is raised and the sticky flag does not change. Control-word writes with bad parity are still applied.
- R6: Cycles with both select inputs high are never checked: bad parity on such a cycle raises no alarm.
- R7: A control-word write with a parity mismatch while checking is enabled leaves every control word unchanged and raises the alarm like any other error.
- R8: A control-word write is a qualified cycle with activate high, the command lines all 0, and bank and bank group both 3. Address bits [11:8] select the word (0 = configuration, 1 = alarm length, 2 = clear) and bits [7:0] carry the data. The write is consumed: one clock later both select outputs are high.
- R9: The odd-rank address outputs swap bit pairs 3/4, 5/6, 7/8 and 11/13 of the registered address, and swap bits 0/1 of both the bank and the bank group. All other bits pass through unchanged.
- R10: The clock-enable and termination-enable outputs follow their inputs one clock later on every cycle, whether or not a command was blocked.
- R11: The sticky flag is set on the clock after any error. It stays set until an accepted write of 1 to bit 0 of word 2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n_i | input | 2 | Active-low rank selects from the controller |
| activate_n_i | input | 1 | Active-low activate strobe |
| cmd_i | input | 3 | Row, column and write command lines |
| addr_i | input | ADDR_W | Address lines |
| bank_i | input | 2 | Bank address |
| bgrp_i | input | 2 | Bank group |
| chk_bit_i | input | 1 | Even-parity bit for the cycle |
| clk_en_i | input | 2 | Per-rank clock enable |
| term_en_i | input | 2 | Per-rank termination enable |
| sel_n_o | output | 2 | Registered rank selects, 11 on block or consume |
| activate_n_o | output | 1 | Registered activate strobe |
| cmd_o | output | 3 | Registered command lines |
| r0_addr_o | output | ADDR_W | Even-rank address |
| r0_bank_o | output | 2 | Even-rank bank |
| r0_bgrp_o | output | 2 | Even-rank bank group |
| r1_addr_o | output | ADDR_W | Odd-rank mirrored address |
| r1_bank_o | output | 2 | Odd-rank mirrored bank |
| r1_bgrp_o | output | 2 | Odd-rank mirrored bank group |
| clk_en_o | output | 2 | Registered clock enables |
| term_en_o | output | 2 | Registered termination enables |
| err_alarm_lo_o | output | 1 | Active-low parity alarm |
| err_seen_o | output | 1 | Sticky parity-error flag |

## Verification
The bench builds the block with ALEN_W = 4 and ALERT_DEF = 3. The reset alarm length is therefore short, so the exact end of an alarm window fits in a few idle cycles and a restart in the middle of a window can be observed. The four-bit length field also lets the bench program a length of 0, which brings the zero-counts-as-one corner within reach. ADDR_W and the mirroring stay at their defaults, so every swapped pair, including 11/13, is exercised.

// File: rtl/ca_reg_pkg.sv
package ca_reg_pkg;

    typedef enum logic [1:0] {
        CL_IDLE = 2'd0,
        CL_DRAM = 2'd1,
        CL_CTRL = 2'd2
    } cmd_class_t;

    typedef enum logic {
        AL_QUIET = 1'b0,
        AL_HOLD  = 1'b1
    } alert_state_t;

    localparam logic [3:0] CW_CONFIG    = 4'd0;
    localparam logic [3:0] CW_ALERT_LEN = 4'd1;
    localparam logic [3:0] CW_CLEAR     = 4'd2;

    // Partner bit for the odd-rank address swap; unpaired bits map to themselves.
    function automatic int mirror_partner(input int i);
        case (i)
            3:  return 4;
            4:  return 3;
            5:  return 6;
            6:  return 5;
            7:  return 8;
            8:  return 7;
            11: return 13;
            13: return 11;
            default: return i;
        endcase
    endfunction

endpackage

// File: rtl/ca_par_decode.sv
module ca_par_decode
    import ca_reg_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [1:0]        sel_n_i,
    input  logic              activate_n_i,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bank_i,
    input  logic [1:0]        bgrp_i,
    input  logic              chk_bit_i,
    output cmd_class_t        cls_o,
    output logic              par_bad_o
);
    logic qualified;
    logic ctrl_shape;

    always_comb begin
        qualified  = (sel_n_i != 2'b11);
        // Control-word write: activate high, command lines low, bank and group all ones.
        ctrl_shape = activate_n_i && (cmd_i == 3'b000) && (&bank_i) && (&bgrp_i);
        par_bad_o  = ^{addr_i, bank_i, bgrp_i, activate_n_i, cmd_i, chk_bit_i};
        if (!qualified)
            cls_o = CL_IDLE;
        else if (ctrl_shape)
            cls_o = CL_CTRL;
        else
            cls_o = CL_DRAM;
    end

endmodule

// File: rtl/ca_ctrl_words.sv
module ca_ctrl_words
    import ca_reg_pkg::*;
#(
    parameter int ALEN_W    = 8,
    parameter int ALERT_DEF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [3:0]        idx_i,
    input  logic [7:0]        data_i,
    output logic              chk_en_o,
    output logic [ALEN_W-1:0] alert_len_o,
    output logic              clr_o
);
    logic              chk_en_q;
    logic [ALEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_en_q <= 1'b1;
            len_q    <= ALEN_W'(ALERT_DEF);
        end else if (wr_en_i) begin
            case (idx_i)
                CW_CONFIG:    chk_en_q <= data_i[0];
                CW_ALERT_LEN: len_q    <= data_i[ALEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        chk_en_o    = chk_en_q;
        alert_len_o = len_q;
        clr_o       = wr_en_i && (idx_i == CW_CLEAR) && data_i[0];
    end

endmodule

// File: rtl/ca_alert_fsm.sv
module ca_alert_fsm
    import ca_reg_pkg::*;
#(
    parameter int ALEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_i,
    input  logic [ALEN_W-1:0] len_i,
    input  logic              clr_i,
    output logic              alarm_lo_o,
    output logic              sticky_o
);
    alert_state_t      state_q, state_d;
    logic [ALEN_W-1:0] cnt_q, cnt_d;
    logic [ALEN_W-1:0] load_val;
    logic              sticky_q;

    always_comb begin
        load_val = (len_i == '0) ? '0 : len_i - 1'b1;
        state_d  = state_q;
        cnt_d    = cnt_q;
        unique case (state_q)
            AL_QUIET: begin
                if (err_i) begin
                    state_d = AL_HOLD;
                    cnt_d   = load_val;
                end
            end
            AL_HOLD: begin
                if (err_i)
                    cnt_d = load_val;
                else if (cnt_q == '0)
                    state_d = AL_QUIET;
                else
                    cnt_d = cnt_q - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= AL_QUIET;
            cnt_q    <= '0;
            sticky_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (err_i)
                sticky_q <= 1'b1;
            else if (clr_i)
                sticky_q <= 1'b0;
        end
    end

    always_comb begin
        alarm_lo_o = (state_q == AL_QUIET);
        sticky_o   = sticky_q;
    end

    p_alarm_after_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> !alarm_lo_o);

    p_sticky_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> sticky_o);

endmodule

// File: rtl/ca_mirror.sv
module ca_mirror
    import ca_reg_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter bit MIRROR_ODD = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bank_i,
    input  logic [1:0]        bgrp_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        bank_o,
    output logic [1:0]        bgrp_o
);
    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
        localparam int PART = mirror_partner(g);
        if (MIRROR_ODD && PART < ADDR_W) begin : g_swap
            assign addr_o[g] = addr_i[PART];
        end else begin : g_pass
            assign addr_o[g] = addr_i[g];
        end
    end

    if (MIRROR_ODD) begin : g_bank_swap
        assign bank_o = {bank_i[0], bank_i[1]};
        assign bgrp_o = {bgrp_i[0], bgrp_i[1]};
    end else begin : g_bank_pass
        assign bank_o = bank_i;
        assign bgrp_o = bgrp_i;
    end

endmodule

// File: rtl/ca_parity_reg.sv
module ca_parity_reg
    import ca_reg_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int ALEN_W     = 8,
    parameter int ALERT_DEF  = 4,
    parameter bit MIRROR_ODD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_n_i,
    input  logic              activate_n_i,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bank_i,
    input  logic [1:0]        bgrp_i,
    input  logic              chk_bit_i,
    input  logic [1:0]        clk_en_i,
    input  logic [1:0]        term_en_i,
    output logic [1:0]        sel_n_o,
    output logic              activate_n_o,
    output logic [2:0]        cmd_o,
    output logic [ADDR_W-1:0] r0_addr_o,
    output logic [1:0]        r0_bank_o,
    output logic [1:0]        r0_bgrp_o,
    output logic [ADDR_W-1:0] r1_addr_o,
    output logic [1:0]        r1_bank_o,
    output logic [1:0]        r1_bgrp_o,
    output logic [1:0]        clk_en_o,
    output logic [1:0]        term_en_o,
    output logic              err_alarm_lo_o,
    output logic              err_seen_o
);
    localparam int IDX_LO = 8;

    cmd_class_t        cls;
    logic              par_bad;
    logic              chk_en;
    logic [ALEN_W-1:0] alert_len;
    logic              clr;
    logic              err;
    logic              cw_wr;
    logic              fwd;

    logic [1:0]        sel_q;
    logic              act_q;
    logic [2:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        bank_q, bgrp_q, cke_q, term_q;

    ca_par_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel_n_i      (sel_n_i),
        .activate_n_i (activate_n_i),
        .cmd_i        (cmd_i),
        .addr_i       (addr_i),
        .bank_i       (bank_i),
        .bgrp_i       (bgrp_i),
        .chk_bit_i    (chk_bit_i),
        .cls_o        (cls),
        .par_bad_o    (par_bad)
    );

    always_comb begin
        err   = (cls != CL_IDLE) && chk_en && par_bad;
        cw_wr = (cls == CL_CTRL) && !err;
        fwd   = (cls == CL_DRAM) && !err;
    end

    ca_ctrl_words #(.ALEN_W(ALEN_W), .ALERT_DEF(ALERT_DEF)) u_words (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (cw_wr),
        .idx_i       (addr_i[IDX_LO+3:IDX_LO]),
        .data_i      (addr_i[7:0]),
        .chk_en_o    (chk_en),
        .alert_len_o (alert_len),
        .clr_o       (clr)
    );

    ca_alert_fsm #(.ALEN_W(ALEN_W)) u_alert (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_i      (err),
        .len_i      (alert_len),
        .clr_i      (clr),
        .alarm_lo_o (err_alarm_lo_o),
        .sticky_o   (err_seen_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 2'b11;
            act_q  <= 1'b1;
            cmd_q  <= '0;
            addr_q <= '0;
            bank_q <= '0;
            bgrp_q <= '0;
            cke_q  <= '0;
            term_q <= '0;
        end else begin
            sel_q  <= fwd ? sel_n_i : 2'b11;
            act_q  <= activate_n_i;
            cmd_q  <= cmd_i;
            addr_q <= addr_i;
            bank_q <= bank_i;
            bgrp_q <= bgrp_i;
            cke_q  <= clk_en_i;
            term_q <= term_en_i;
        end
    end

    ca_mirror #(.ADDR_W(ADDR_W), .MIRROR_ODD(MIRROR_ODD)) u_mirror (
        .addr_i (addr_q),
        .bank_i (bank_q),
        .bgrp_i (bgrp_q),
        .addr_o (r1_addr_o),
        .bank_o (r1_bank_o),
        .bgrp_o (r1_bgrp_o)
    );

    always_comb begin
        sel_n_o      = sel_q;
        activate_n_o = act_q;
        cmd_o        = cmd_q;
        r0_addr_o    = addr_q;
        r0_bank_o    = bank_q;
        r0_bgrp_o    = bgrp_q;
        clk_en_o     = cke_q;
        term_en_o    = term_q;
    end

    p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CL_DRAM && !par_bad) |=> (sel_n_o == $past(sel_n_i)));

    p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls != CL_IDLE && chk_en && par_bad) |=> (sel_n_o == 2'b11));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((&sel_n_i) && err_alarm_lo_o) |=> err_alarm_lo_o);

    p_bad_cw_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CL_CTRL && err) |=> ($stable(chk_en) && $stable(alert_len)));

    p_cw_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CL_CTRL) |=> (sel_n_o == 2'b11));

endmodule

// File: tb/ca_parity_reg_bench.sv
module ca_parity_reg_bench;
    localparam int AW = 18;

    typedef struct {
        logic [1:0]    sel;
        logic [AW-1:0] a0;
        logic [AW-1:0] a1;
        logic [3:0]    bb1;
        logic [1:0]    ce;
        logic          al;
        logic          st;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sel_n_i = 2'b11;
    logic activate_n_i = 1'b1;
    logic [2:0] cmd_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [1:0] bank_i = '0, bgrp_i = '0, clk_en_i = '0, term_en_i = '0;
    logic chk_bit_i = 1'b0;
    logic [1:0] sel_n_o, r0_bank_o, r0_bgrp_o, r1_bank_o, r1_bgrp_o, clk_en_o, term_en_o;
    logic activate_n_o, err_alarm_lo_o, err_seen_o;
    logic [2:0] cmd_o;
    logic [AW-1:0] r0_addr_o, r1_addr_o;

    int total = 0;
    int bad = 0;
    exp_t q[$];

    // model state
    logic m_chk = 1'b1;
    int   m_len = 3;
    int   m_rem = 0;
    logic m_st = 1'b0;

    always #2 clk = ~clk;

    ca_parity_reg #(.ADDR_W(AW), .ALEN_W(4), .ALERT_DEF(3), .MIRROR_ODD(1'b1)) u_ca_parity_reg (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .activate_n_i(activate_n_i),
        .cmd_i(cmd_i), .addr_i(addr_i), .bank_i(bank_i), .bgrp_i(bgrp_i),
        .chk_bit_i(chk_bit_i), .clk_en_i(clk_en_i), .term_en_i(term_en_i),
        .sel_n_o(sel_n_o), .activate_n_o(activate_n_o), .cmd_o(cmd_o),
        .r0_addr_o(r0_addr_o), .r0_bank_o(r0_bank_o), .r0_bgrp_o(r0_bgrp_o),
        .r1_addr_o(r1_addr_o), .r1_bank_o(r1_bank_o), .r1_bgrp_o(r1_bgrp_o),
        .clk_en_o(clk_en_o), .term_en_o(term_en_o),
        .err_alarm_lo_o(err_alarm_lo_o), .err_seen_o(err_seen_o)
    );

    function automatic logic [AW-1:0] mirror_addr(input logic [AW-1:0] a);
        logic [AW-1:0] m = a;
        m[3] = a[4];  m[4] = a[3];
        m[5] = a[6];  m[6] = a[5];
        m[7] = a[8];  m[8] = a[7];
        m[11] = a[13]; m[13] = a[11];
        return m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] sel, input logic act, input logic [2:0] cmd,
                         input logic [AW-1:0] a, input logic [1:0] ba, input logic [1:0] bg,
                         input logic flip, input logic [1:0] ce, input string tag);
        exp_t e;
        logic valid, perr, is_cw, err;
        @(negedge clk);
        sel_n_i = sel; activate_n_i = act; cmd_i = cmd; addr_i = a;
        bank_i = ba; bgrp_i = bg; clk_en_i = ce; term_en_i = ~ce;
        chk_bit_i = (^{a, ba, bg, act, cmd}) ^ flip;
        valid = (sel != 2'b11);
        perr  = flip;
        is_cw = valid && act && (cmd == 3'b000) && (ba == 2'b11) && (bg == 2'b11);
        err   = valid && m_chk && perr;
        if (err) m_rem = (m_len == 0) ? 1 : m_len;
        else if (m_rem > 0) m_rem--;
        if (err) m_st = 1'b1;
        else if (is_cw && a[11:8] == 4'd2 && a[0]) m_st = 1'b0;
        if (is_cw && !err) begin
            if (a[11:8] == 4'd0) m_chk = a[0];
            if (a[11:8] == 4'd1) m_len = int'(a[3:0]);
        end
        e.sel = (valid && !err && !is_cw) ? sel : 2'b11;
        e.a0  = a;
        e.a1  = mirror_addr(a);
        e.bb1 = {bg[0], bg[1], ba[0], ba[1]};
        e.ce  = ce;
        e.al  = (m_rem == 0);
        e.st  = m_st;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input logic flip);
        for (int i = 0; i < n; i++)
            drive(2'b11, 1'b0, 3'b101, AW'(18'h3C0F0 + i), 2'b10, 2'b01, flip, 2'b11, "R6");
    endtask

    task automatic cw(input logic [3:0] idx, input logic [7:0] d, input logic flip, input string tag);
        drive(2'b10, 1'b1, 3'b000, {6'b0, idx, d}, 2'b11, 2'b11, flip, 2'b10, tag);
    endtask

    // monitor: compares one expected item per clock, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " sel"}, 32'(sel_n_o), 32'(e.sel));
                check("R2 rank0 addr", 32'(r0_addr_o), 32'(e.a0));
                check("R9 rank1 addr", 32'(r1_addr_o), 32'(e.a1));
                check("R9 rank1 bank/group", 32'({r1_bgrp_o, r1_bank_o}), 32'(e.bb1));
                check("R10 clk_en", 32'({clk_en_o, term_en_o}), 32'({e.ce, ~e.ce}));
                check("R4 alarm", 32'(err_alarm_lo_o), 32'(e.al));
                check("R11 sticky", 32'(err_seen_o), 32'(e.st));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 sel in reset", 32'(sel_n_o), 32'h3);
        check("R1 alarm in reset", 32'(err_alarm_lo_o), 32'h1);
        check("R1 sticky in reset", 32'(err_seen_o), 32'h0);
        check("R1 clk_en in reset", 32'(clk_en_o), 32'h0);
        rst_n = 1'b1;
        idle(2, 1'b0);
        // R2 / R9 / R10: good commands on each rank
        drive(2'b10, 1'b0, 3'b011, 18'h2A5A8, 2'b01, 2'b10, 1'b0, 2'b01, "R2");
        drive(2'b01, 1'b0, 3'b100, 18'h02948, 2'b10, 2'b01, 1'b0, 2'b10, "R2");
        drive(2'b01, 1'b1, 3'b110, 18'h01FF8, 2'b00, 2'b11, 1'b0, 2'b11, "R2");
        // R6: unqualified cycles with wrong parity
        idle(2, 1'b1);
        // R3 / R4 / R11: blocked command, alarm of default length 3
        drive(2'b10, 1'b0, 3'b100, 18'h01234, 2'b00, 2'b00, 1'b1, 2'b01, "R3");
        idle(4, 1'b0);
        // R4: restart while alarm low
        drive(2'b01, 1'b0, 3'b010, 18'h00F0F, 2'b01, 2'b01, 1'b1, 2'b00, "R3");
        idle(1, 1'b0);
        drive(2'b10, 1'b0, 3'b010, 18'h30303, 2'b10, 2'b00, 1'b1, 2'b00, "R3");
        idle(4, 1'b0);
        // R8 + R4: length 0 behaves as 1
        cw(4'd1, 8'd0, 1'b0, "R8");
        drive(2'b10, 1'b0, 3'b001, 18'h0AAAA, 2'b00, 2'b01, 1'b1, 2'b01, "R4");
        idle(2, 1'b0);
        cw(4'd1, 8'd2, 1'b0, "R8");
        // R7: bad-parity write to disable checking is rejected
        cw(4'd0, 8'h00, 1'b1, "R7");
        idle(3, 1'b0);
        drive(2'b01, 1'b0, 3'b111, 18'h15555, 2'b11, 2'b10, 1'b1, 2'b10, "R7");
        idle(3, 1'b0);
        // R11: clear sticky
        cw(4'd2, 8'h01, 1'b0, "R11");
        idle(1, 1'b0);
        // R5: checking disabled
        cw(4'd0, 8'h00, 1'b0, "R5");
        drive(2'b10, 1'b0, 3'b011, 18'h3FFFF, 2'b01, 2'b10, 1'b1, 2'b11, "R5");
        drive(2'b01, 1'b0, 3'b101, 18'h24924, 2'b10, 2'b01, 1'b1, 2'b01, "R5");
        cw(4'd0, 8'h01, 1'b1, "R5");
        drive(2'b10, 1'b0, 3'b011, 18'h12345, 2'b01, 2'b00, 1'b1, 2'b10, "R3");
        idle(4, 1'b0);
        @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule